// File: doc/BRIEF.md
# SPI Master with Register Port

This block is an 8-bit, full-duplex SPI master that software drives through a small slave bus port. The bus port has a 2-bit address, 8-bit write and read data, and cycle, strobe and write-enable qualifiers. It returns a one-cycle acknowledge for each access. Four byte-wide registers sit behind it: mode control, status, shift data and divider extension.

Software first sets the clock polarity, clock phase and rate in the mode control register, and writes any extra division into the extension register. A write to the data register then starts one byte transfer. MOSI is sent most significant bit first, and MISO is captured into a receive byte at the same time. When the byte is finished, a sticky flag is set. It can raise the interrupt output. Software clears the flag explicitly.

Slave select is not generated here. The transmit and receive paths each hold one byte.

Top module: `spim_ctrl`

## Requirements
- R1: After reset every register reads 0, `sck_o` is low and `inta_o` is low. Mode control (address 0) and divider extension (address 3) read back exactly the byte last written to them.
- R2: Each accepted access (`cyc_i` and `stb_i` high while `ack_o` is low) gives `ack_o` high for exactly one cycle.
- R3: A write to the data register (address 2) starts one 8-bit transfer when mode control bit 6 is 1 and no transfer is running. `mosi_o` carries the written byte, most significant bit first.
- R4: The byte sampled from `miso_i` during a transfer is captured MSB first. Reading the data register after completion returns it.
- R5: Status bit 7 sets when a transfer completes. It stays set until a status write (address 1) with bit 7 = 1. A status write with bit 7 = 0 leaves it unchanged. If the completion and the clearing write fall in the same cycle, the flag stays set.
- R6: `sck_o` idles at mode control bit 3 (polarity) and returns to that level after 16 edges. Mode control bit 2 selects the phase. With phase 0, data is sampled on odd-numbered edges and the first bit is driven before the first edge. With phase 1, data is sampled on even-numbered edges (edges counted from 1).
- R7: The SCK half period, in system clocks, is 1, 2, 8 or 16 for mode control bits 1:0 = 0, 1, 2, 3. This value is shifted left by extension bits 1:0. A value of 0 in those bits adds no division.
- R8: A data write during a transfer is ignored and sets status bit 6. Writing status with bit 6 = 1 clears it.
- R9: `inta_o` is high exactly when mode control bit 7 and status bit 7 are both 1.
- R10: A data write while mode control bit 6 is 0 starts nothing. No SCK edge occurs and the status stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle qualifier |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | 2 | Register address |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Access acknowledge |
| inta_o | output | 1 | Completion interrupt |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |

## Verification
Two events can meet in one cycle: the engine raising the completion flag, and a software status write clearing that same flag. The bench runs a transfer at the fastest rate, where the last SCK edge falls a fixed number of cycles after the data write is accepted. It then times a status write with bit 7 set so that it is accepted on exactly the edge where the flag sets. It judges the result by reading status afterwards: bit 7 must still be 1, and a later clear must then succeed. A second meeting point is a data write that arrives during a transfer. The bench checks that it leaves the serial byte and the received byte untouched.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 8;

  typedef enum logic [1:0] {
    ADR_MODE = 2'd0,
    ADR_STAT = 2'd1,
    ADR_DATA = 2'd2,
    ADR_EXT  = 2'd3
  } reg_adr_e;

  // half SCK period in system clocks
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic [1:0] xdiv);
    logic [HALF_W-1:0] base;
    case (rate)
      2'd0:    base = HALF_W'(1);
      2'd1:    base = HALF_W'(2);
      2'd2:    base = HALF_W'(8);
      default: base = HALF_W'(16);
    endcase
    return base << xdiv;
  endfunction
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] half_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q == half_i - W'(1));
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || wrap)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + W'(1);
  end

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half_i)); // R7
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DW     = 8,
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DW-1:0]     txd_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic [HALF_W-1:0] half_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     rxd_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int CNT_W = $clog2(2 * DW);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(2 * DW - 1);

  logic [DW-1:0]     tx_q, rx_q;
  logic [CNT_W-1:0]  edge_q;
  logic              busy_q, done_q, sck_q, cpol_q, cpha_q;
  logic [HALF_W-1:0] half_q;
  logic              sample, shift;

  // edge_q[0]==0 marks a leading edge
  assign sample = (edge_q[0] == cpha_q);
  assign shift  = !sample && !(cpha_q && edge_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0; rx_q <= '0; edge_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; sck_q <= 1'b0;
      cpol_q <= 1'b0; cpha_q <= 1'b0; half_q <= HALF_W'(1);
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        tx_q   <= txd_i;
        cpol_q <= cpol_i;
        cpha_q <= cpha_i;
        half_q <= half_i;
        sck_q  <= cpol_i;
        edge_q <= '0;
      end else if (busy_q && tick_i) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + CNT_W'(1);
        if (sample) rx_q <= {rx_q[DW-2:0], miso_i};
        if (shift)  tx_q <= {tx_q[DW-2:0], 1'b0};
        if (edge_q == LAST_EDGE) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign half_o = half_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rxd_o  = rx_q;
  assign sck_o  = busy_q ? sck_q : cpol_i;
  assign mosi_o = tx_q[DW-1];

  AST_SCK_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (sck_q == cpol_q)); // R6
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> $stable(tx_q)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R5
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cyc_i,
  input  logic       stb_i,
  input  logic       we_i,
  input  logic [1:0] adr_i,
  input  logic [7:0] dat_i,
  output logic [7:0] dat_o,
  output logic       ack_o,
  output logic       inta_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  logic [7:0]        mode_q, ext_q, rxbuf_q;
  logic              ack_q, done_f, wcol_f;
  logic              acc, wr, wr_data, start, busy, xfer_done, tick;
  logic [HALF_W-1:0] half_req, half_run;
  logic [BYTE_W-1:0] rxd;

  assign acc     = cyc_i && stb_i && !ack_q;
  assign wr      = acc && we_i;
  assign wr_data = wr && (adr_i == ADR_DATA) && mode_q[6];
  assign start   = wr_data && !busy;
  assign half_req = half_period(mode_q[1:0], ext_q[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; ext_q <= '0; rxbuf_q <= '0;
      ack_q <= 1'b0; done_f <= 1'b0; wcol_f <= 1'b0;
    end else begin
      ack_q <= acc;
      if (wr && adr_i == ADR_MODE) mode_q <= dat_i;
      if (wr && adr_i == ADR_EXT)  ext_q  <= dat_i;
      if (wr && adr_i == ADR_STAT && dat_i[6]) wcol_f <= 1'b0;
      if (wr_data && busy) wcol_f <= 1'b1;
      // completion wins over a same-cycle clear
      if (xfer_done) begin
        done_f  <= 1'b1;
        rxbuf_q <= rxd;
      end else if (wr && adr_i == ADR_STAT && dat_i[7]) begin
        done_f <= 1'b0;
      end
    end
  end

  always_comb begin
    case (adr_i)
      ADR_MODE: dat_o = mode_q;
      ADR_STAT: dat_o = {done_f, wcol_f, 6'b0};
      ADR_DATA: dat_o = rxbuf_q;
      default:  dat_o = ext_q;
    endcase
  end

  assign ack_o  = ack_q;
  assign inta_o = mode_q[7] && done_f;

  spim_clkdiv #(.W(HALF_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .half_i(half_run),
    .tick_o(tick)
  );

  spim_shift #(.DW(BYTE_W), .HALF_W(HALF_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .txd_i  (dat_i),
    .cpol_i (mode_q[3]),
    .cpha_i (mode_q[2]),
    .half_i (half_req),
    .tick_i (tick),
    .miso_i (miso_i),
    .half_o (half_run),
    .busy_o (busy),
    .done_o (xfer_done),
    .rxd_o  (rxd),
    .sck_o  (sck_o),
    .mosi_o (mosi_o)
  );

  AST_ACK_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q); // R2
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_f && !(wr && adr_i == ADR_STAT && dat_i[7])) |=> done_f); // R5
  AST_WCOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && busy) |=> wcol_f); // R8
  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && adr_i == ADR_DATA && !mode_q[6] && !busy) |=> !busy); // R10
  AST_DONE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_f) |-> $past(busy, 2)); // R5
endmodule

// File: tb/spim_ctrl_test.sv
`timescale 1ns/1ps
module spim_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [1:0] adr = '0;
  logic [7:0] wdat = '0, rdat;
  logic ack, inta, sck, mosi, miso;

  int checks = 0, errors = 0;
  int e = 0, half_meas = 0;
  bit mon_en = 1'b0, mon_cpha = 1'b0;
  logic [7:0] mcap = '0, slv = '0;
  time t1 = 0;

  always #2 clk = ~clk;

  spim_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack), .inta_o(inta),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
  );

  // slave model: bit index from edges seen so far
  function automatic int bit_idx(input int n, input bit ph);
    int k;
    k = ph ? ((n == 0) ? 0 : (n - 1) / 2) : n / 2;
    if (k > 7) k = 7;
    return 7 - k;
  endfunction
  assign miso = slv[bit_idx(e, mon_cpha)];

  always @(sck) begin
    if (mon_en) begin
      e = e + 1;
      if ((e % 2 == 1) != mon_cpha) mcap = {mcap[6:0], mosi};
      if (e == 1) t1 = $time;
      if (e == 2) half_meas = int'(($time - t1) / 4);
    end
  end

  function automatic int exp_half(input logic [1:0] rate, input logic [1:0] xd);
    int b;
    case (rate) 2'd0: b = 1; 2'd1: b = 2; 2'd2: b = 8; default: b = 16; endcase
    return b << xd;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic bus(input logic w, input logic [1:0] a, input logic [7:0] d, output logic [7:0] q);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(posedge clk); @(negedge clk);
    q = rdat;
    chk(ack === 1'b1, "R2 ack", int'(ack), 1);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    chk(ack === 1'b0, "R2 ack drop", int'(ack), 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    bus(1'b0, a, 8'h00, q);
  endtask

  task automatic arm(input bit ph, input logic [7:0] s);
    slv = s; mon_cpha = ph; e = 0; mcap = '0; half_meas = 0; mon_en = 1'b1;
  endtask

  task automatic wait_done(output logic [7:0] q);
    int n = 0;
    rd(2'd1, q);
    while (!q[7] && n < 3000) begin rd(2'd1, q); n++; end
    mon_en = 1'b0;
  endtask

  // {cpol,cpha,rate,2'b0,ext}, mosi byte, miso byte
  localparam logic [23:0] VEC [8] = '{
    24'h00_A5_3C, 24'h50_5A_C3, 24'hA0_81_7E, 24'hF0_01_80,
    24'h12_F0_0F, 24'hC3_96_69, 24'h71_7F_FE, 24'h81_00_FF
  };

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(sck === 1'b0, "R1 sck", int'(sck), 0);
    chk(inta === 1'b0, "R1 inta", int'(inta), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), q);
      chk(q === 8'h00, "R1 reset reg", int'(q), 0);
    end

    // R10 disabled core ignores data write
    wr(2'd0, 8'h10);
    arm(1'b0, 8'h55);
    wr(2'd2, 8'hAA);
    repeat (50) @(negedge clk);
    mon_en = 1'b0;
    chk(e == 0, "R10 no sck edge", e, 0);
    rd(2'd1, q);
    chk(q === 8'h00, "R10 status", int'(q), 0);

    // table: all modes and rates back to back
    for (int i = 0; i < 8; i++) begin
      logic [7:0] cfg, txb, sb, mode;
      {cfg, txb, sb} = VEC[i];
      mode = {4'b0101, cfg[7], cfg[6], cfg[5:4]};
      wr(2'd0, mode);
      wr(2'd3, {6'b0, cfg[1:0]});
      rd(2'd0, q); chk(q === mode, "R1 mode readback", int'(q), int'(mode));
      rd(2'd3, q); chk(q === {6'b0, cfg[1:0]}, "R1 ext readback", int'(q), int'(cfg[1:0]));
      chk(sck === cfg[7], "R6 idle level", int'(sck), int'(cfg[7]));
      arm(cfg[6], sb);
      wr(2'd2, txb);
      wait_done(q);
      chk(q[7] === 1'b1, "R5 done set", int'(q), 8'h80);
      chk(mcap === txb, "R3 mosi msb first", int'(mcap), int'(txb));
      chk(e == 16, "R6 edge count", e, 16);
      chk(sck === cfg[7], "R6 return level", int'(sck), int'(cfg[7]));
      chk(half_meas == exp_half(cfg[5:4], cfg[1:0]), "R7 half period", half_meas, exp_half(cfg[5:4], cfg[1:0]));
      chk(inta === 1'b0, "R9 masked", int'(inta), 0);
      rd(2'd2, q); chk(q === sb, "R4 rx byte", int'(q), int'(sb));
      wr(2'd1, 8'h80);
      rd(2'd1, q); chk(q === 8'h00, "R5 cleared", int'(q), 0);
    end

    // R8 collision write ignored
    wr(2'd0, 8'h53);
    wr(2'd3, 8'h00);
    arm(1'b0, 8'h5A);
    wr(2'd2, 8'hC3);
    wr(2'd2, 8'h11);
    rd(2'd1, q); chk(q === 8'h40, "R8 wcol set", int'(q), 8'h40);
    wait_done(q);
    chk(mcap === 8'hC3, "R8 mosi unchanged", int'(mcap), 8'hC3);
    rd(2'd2, q); chk(q === 8'h5A, "R8 rx unchanged", int'(q), 8'h5A);
    wr(2'd1, 8'h40);
    rd(2'd1, q); chk(q === 8'h80, "R8 wcol clear", int'(q), 8'h80);
    wr(2'd1, 8'h00);
    rd(2'd1, q); chk(q === 8'h80, "R5 write zero keeps", int'(q), 8'h80);
    wr(2'd1, 8'h80);

    // R9 interrupt enabled
    wr(2'd0, 8'hD0);
    arm(1'b0, 8'h12);
    wr(2'd2, 8'h34);
    wait_done(q);
    chk(inta === 1'b1, "R9 inta high", int'(inta), 1);
    wr(2'd1, 8'h80);
    chk(inta === 1'b0, "R9 inta low", int'(inta), 0);

    // R5 completion and clear in the same cycle: set wins
    wr(2'd0, 8'h50);
    arm(1'b0, 8'h00);
    wr(2'd2, 8'hFF);
    repeat (15) @(negedge clk);
    wr(2'd1, 8'h80);
    rd(2'd1, q); chk(q[7] === 1'b1, "R5 set beats clear", int'(q), 8'h80);
    mon_en = 1'b0;
    wr(2'd1, 8'h80);
    rd(2'd1, q); chk(q === 8'h00, "R5 later clear", int'(q), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule